// File: doc/BRIEF.md
# Read/Write Burst Symbol Assembler for Device-Correcting ECC

This block sits between a 72-bit DDR2 memory data path and a symbol-oriented ECC decoder and encoder. On reads it collects an eight-beat burst. It rearranges the nibbles of each beat so that the four nibbles one x4 DRAM device supplies over a half burst become two adjacent 8-bit symbols of a single 288-bit code word. Beats 0 to 3 form the first half-line code word and beats 4 to 7 form the second. Each code word is presented for one cycle with a valid strobe and a half-line index.

On writes the block runs the same mapping in reverse. It accepts two code words on a start pulse and emits eight 72-bit beats on consecutive cycles. Because every device owns exactly two adjacent symbols, a decoder that corrects any two adjacent bad symbols can repair a whole failed device. The code word is systematic: the data symbols occupy the low field and the check symbols occupy the high field.

Top module: `ecc_burst_symbol_assembler`

## Requirements
- R1: After reset, `cw_vld` and `wr_beat_vld` are 0 and `wr_ready` is 1.
- R2: On the read path, nibble lane d (beat bits 4d+3..4d, d = 0..17) of the beat with position b (0..3) inside its half burst lands in code-word nibble 4d+b, which is code-word bits 16d+4b+3..16d+4b.
- R3: Code-word bits 255..0 (data symbols 0..31) come only from beat lanes 0..15. Bits 287..256 (check symbols 32..35) come only from lanes 16 and 17.
- R4: `cw_vld` is high for exactly the one cycle after the fourth and the eighth accepted beat. `cw_half` is 0 for the first of these and 1 for the second. Cycles with `rd_beat_vld` low do not advance the beat count.
- R5: `rd_abort` resets the beat count to the start of a line and discards any partial code word. It wins over a beat presented in the same cycle, so no `cw_vld` follows from that beat.
- R6: A fault that forces every nibble of one lane d to a fixed value changes, in each code word, only symbols 2d and 2d+1 (bits 16d+15..16d).
- R7: A `wr_start` accepted while `wr_ready` is 1 makes `wr_beat_vld` high for the next eight cycles. Beat k carries nibble 4d+(k mod 4) of code word `wr_cw_lo` (k < 4) or `wr_cw_hi` (k >= 4) on lane d.
- R8: `wr_ready` is 0 during write beats 0 to 6. A `wr_start` while `wr_ready` is 0 is ignored and does not change the beats being sent.
- R9: `wr_ready` is 1 during write beat 7. A start taken then begins the next line's beat 0 in the following cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_beat_vld | input | 1 | Read beat present this cycle |
| rd_beat | input | 72 | Read beat, 18 nibble lanes |
| rd_abort | input | 1 | Abandon the current read burst |
| cw_vld | output | 1 | Assembled code word valid (one cycle) |
| cw_half | output | 1 | Half-line index of the code word |
| cw_data | output | 288 | Assembled code word |
| wr_start | input | 1 | Load two code words for writing |
| wr_cw_lo | input | 288 | Code word for beats 0..3 |
| wr_cw_hi | input | 288 | Code word for beats 4..7 |
| wr_ready | output | 1 | Write start can be accepted |
| wr_beat_vld | output | 1 | Write beat valid |
| wr_beat | output | 72 | Write beat, 18 nibble lanes |

## Verification
Two pairs of events can fall in the same cycle. On the read side, an abort can arrive together with the fourth beat of a half. On the write side, a new start can arrive on the last beat of the line in progress. The bench drives the beat and the abort in one cycle and expects no strobe. It then sends a full clean line and expects half index 0 and then 1 with the correct data. On the write side, the bench raises the start during beat 7. It expects beat 0 of the new line in the very next cycle and all sixteen beats to match the inverse mapping.

// File: rtl/ecc_asm_pkg.sv
package ecc_asm_pkg;

   typedef enum logic {
      WR_IDLE = 1'b0,
      WR_SEND = 1'b1
   } wr_state_e;

   // Index of the code-word nibble that holds lane `lane` of beat `slot`.
   function automatic int cw_nib_idx(input int lane, input int slot, input int beats_per_half);
      return lane * beats_per_half + slot;
   endfunction

endpackage

// File: rtl/ecc_beat_scatter.sv
module ecc_beat_scatter #(
   parameter int NIB_W          = 4,
   parameter int LANES          = 18,
   parameter int BEATS_PER_HALF = 4
) (
   input  logic [NIB_W*LANES*BEATS_PER_HALF-1:0] acc_in,
   input  logic [NIB_W*LANES-1:0]                beat,
   input  logic [$clog2(BEATS_PER_HALF)-1:0]     slot,
   output logic [NIB_W*LANES*BEATS_PER_HALF-1:0] acc_out
);
   localparam int SLOT_W = $clog2(BEATS_PER_HALF);

   for (genvar d = 0; d < LANES; d++) begin : g_lane
      for (genvar s = 0; s < BEATS_PER_HALF; s++) begin : g_slot
         localparam int K = ecc_asm_pkg::cw_nib_idx(d, s, BEATS_PER_HALF);
         assign acc_out[K*NIB_W +: NIB_W] = (slot == SLOT_W'(s)) ?
                                            beat[d*NIB_W +: NIB_W] :
                                            acc_in[K*NIB_W +: NIB_W];
      end
   end

endmodule

// File: rtl/ecc_beat_gather.sv
module ecc_beat_gather #(
   parameter int NIB_W          = 4,
   parameter int LANES          = 18,
   parameter int BEATS_PER_HALF = 4
) (
   input  logic [NIB_W*LANES*BEATS_PER_HALF-1:0] cw,
   input  logic [$clog2(BEATS_PER_HALF)-1:0]     slot,
   output logic [NIB_W*LANES-1:0]                beat
);
   localparam int SLOT_W = $clog2(BEATS_PER_HALF);

   for (genvar d = 0; d < LANES; d++) begin : g_lane
      logic [BEATS_PER_HALF-1:0][NIB_W-1:0] dev_nibs;
      for (genvar s = 0; s < BEATS_PER_HALF; s++) begin : g_slot
         localparam int K = ecc_asm_pkg::cw_nib_idx(d, s, BEATS_PER_HALF);
         assign dev_nibs[s] = cw[K*NIB_W +: NIB_W];
      end
      assign beat[d*NIB_W +: NIB_W] = dev_nibs[slot];
   end

endmodule

// File: rtl/ecc_rd_assembler.sv
module ecc_rd_assembler #(
   parameter int NIB_W          = 4,
   parameter int LANES          = 18,
   parameter int BEATS_PER_HALF = 4,
   parameter int HALVES         = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   beat_vld,
   input  logic [NIB_W*LANES-1:0]                 beat,
   input  logic                                   abort,
   output logic                                   cw_vld,
   output logic [$clog2(HALVES)-1:0]              cw_half,
   output logic [NIB_W*LANES*BEATS_PER_HALF-1:0]  cw_data
);
   localparam int BEAT_W = NIB_W * LANES;
   localparam int CW_W   = BEAT_W * BEATS_PER_HALF;
   localparam int SLOT_W = $clog2(BEATS_PER_HALF);
   localparam int HALF_W = $clog2(HALVES);
   localparam int CNT_W  = SLOT_W + HALF_W;

   logic [CNT_W-1:0]  cnt;
   logic [SLOT_W-1:0] slot;
   logic [HALF_W-1:0] half;
   logic              slot_last;
   logic [CW_W-1:0]   acc;
   logic [CW_W-1:0]   merged;

   assign slot      = cnt[SLOT_W-1:0];
   assign half      = cnt[CNT_W-1:SLOT_W];
   assign slot_last = (slot == SLOT_W'(BEATS_PER_HALF - 1));

   ecc_beat_scatter #(
      .NIB_W          (NIB_W),
      .LANES          (LANES),
      .BEATS_PER_HALF (BEATS_PER_HALF)
   ) u_scatter (
      .acc_in  (acc),
      .beat    (beat),
      .slot    (slot),
      .acc_out (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         acc     <= '0;
         cw_vld  <= 1'b0;
         cw_half <= '0;
         cw_data <= '0;
      end else begin
         cw_vld <= 1'b0;
         if (abort) begin
            cnt <= '0;
         end else if (beat_vld) begin
            acc <= merged;
            cnt <= cnt + 1'b1;
            if (slot_last) begin
               cw_data <= merged;
               cw_half <= half;
               cw_vld  <= 1'b1;
            end
         end
      end
   end

   AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cw_vld |=> !cw_vld);                                                    // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_vld && !abort) |=> ($stable(cnt) && !cw_vld));                   // R4
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (cnt == '0 && !cw_vld));                                       // R5

endmodule

// File: rtl/ecc_wr_serializer.sv
module ecc_wr_serializer #(
   parameter int NIB_W          = 4,
   parameter int LANES          = 18,
   parameter int BEATS_PER_HALF = 4,
   parameter int HALVES         = 2
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        start,
   input  logic [HALVES*NIB_W*LANES*BEATS_PER_HALF-1:0] cw_all,
   output logic                                        ready,
   output logic                                        beat_vld,
   output logic [NIB_W*LANES-1:0]                      beat
);
   import ecc_asm_pkg::*;

   localparam int BEAT_W = NIB_W * LANES;
   localparam int CW_W   = BEAT_W * BEATS_PER_HALF;
   localparam int SLOT_W = $clog2(BEATS_PER_HALF);
   localparam int HALF_W = $clog2(HALVES);
   localparam int CNT_W  = SLOT_W + HALF_W;
   localparam int TOTAL  = BEATS_PER_HALF * HALVES;

   wr_state_e                state;
   logic [CNT_W-1:0]         idx;
   logic [HALVES*CW_W-1:0]   store;
   logic                     last;
   logic                     accept;
   logic [CW_W-1:0]          sel_cw;

   assign last     = (state == WR_SEND) && (idx == CNT_W'(TOTAL - 1));
   assign ready    = (state == WR_IDLE) || last;
   assign accept   = start && ready;
   assign beat_vld = (state == WR_SEND);
   assign sel_cw   = store[idx[CNT_W-1:SLOT_W]*CW_W +: CW_W];

   ecc_beat_gather #(
      .NIB_W          (NIB_W),
      .LANES          (LANES),
      .BEATS_PER_HALF (BEATS_PER_HALF)
   ) u_gather (
      .cw   (sel_cw),
      .slot (idx[SLOT_W-1:0]),
      .beat (beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WR_IDLE;
         idx   <= '0;
         store <= '0;
      end else if (accept) begin
         state <= WR_SEND;
         idx   <= '0;
         store <= cw_all;
      end else if (state == WR_SEND) begin
         idx <= idx + 1'b1;
         if (last) begin
            state <= WR_IDLE;
         end
      end
   end

   AST_WR_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !last) |=> (beat_vld && idx == $past(idx) + 1'b1));       // R7
   AST_WR_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ready) |=> $stable(store));                                  // R8
   AST_WR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (start && ready) |=> (beat_vld && idx == '0));                          // R9

endmodule

// File: rtl/ecc_burst_symbol_assembler.sv
module ecc_burst_symbol_assembler #(
   parameter int NIB_W          = 4,
   parameter int LANES          = 18,
   parameter int DATA_LANES     = 16,
   parameter int BEATS_PER_HALF = 4,
   parameter int HALVES         = 2,
   localparam int BEAT_W        = NIB_W * LANES,
   localparam int CW_W          = BEAT_W * BEATS_PER_HALF,
   localparam int HALF_W        = $clog2(HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_beat_vld,
   input  logic [BEAT_W-1:0] rd_beat,
   input  logic              rd_abort,
   output logic              cw_vld,
   output logic [HALF_W-1:0] cw_half,
   output logic [CW_W-1:0]   cw_data,
   input  logic              wr_start,
   input  logic [CW_W-1:0]   wr_cw_lo,
   input  logic [CW_W-1:0]   wr_cw_hi,
   output logic              wr_ready,
   output logic              wr_beat_vld,
   output logic [BEAT_W-1:0] wr_beat
);
   // Elaboration-time parameter checks
   if (BEATS_PER_HALF < 2 || (BEATS_PER_HALF & (BEATS_PER_HALF - 1)) != 0) begin : g_bad_bph
      $error("BEATS_PER_HALF must be a power of two, at least 2");
   end
   if (HALVES < 2 || (HALVES & (HALVES - 1)) != 0) begin : g_bad_halves
      $error("HALVES must be a power of two, at least 2");
   end
   if (DATA_LANES < 1 || DATA_LANES >= LANES) begin : g_bad_lanes
      $error("DATA_LANES must leave at least one check lane");
   end
   if (NIB_W < 1) begin : g_bad_nib
      $error("NIB_W must be positive");
   end

   logic [HALVES*CW_W-1:0] wr_cw_all;

   if (HALVES == 2) begin : g_two_halves
      assign wr_cw_all = {wr_cw_hi, wr_cw_lo};
   end else begin : g_more_halves
      assign wr_cw_all = {{((HALVES - 2) * CW_W){1'b0}}, wr_cw_hi, wr_cw_lo};
   end

   ecc_rd_assembler #(
      .NIB_W          (NIB_W),
      .LANES          (LANES),
      .BEATS_PER_HALF (BEATS_PER_HALF),
      .HALVES         (HALVES)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .beat_vld (rd_beat_vld),
      .beat     (rd_beat),
      .abort    (rd_abort),
      .cw_vld   (cw_vld),
      .cw_half  (cw_half),
      .cw_data  (cw_data)
   );

   ecc_wr_serializer #(
      .NIB_W          (NIB_W),
      .LANES          (LANES),
      .BEATS_PER_HALF (BEATS_PER_HALF),
      .HALVES         (HALVES)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (wr_start),
      .cw_all   (wr_cw_all),
      .ready    (wr_ready),
      .beat_vld (wr_beat_vld),
      .beat     (wr_beat)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!cw_vld && !wr_beat_vld));                                  // R1

endmodule

// File: tb/tb_ecc_burst_symbol_assembler.sv
`timescale 1ns/1ps
module tb_ecc_burst_symbol_assembler;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_beat_vld = 1'b0;
   logic [71:0]  rd_beat = '0;
   logic         rd_abort = 1'b0;
   logic         cw_vld;
   logic [0:0]   cw_half;
   logic [287:0] cw_data;
   logic         wr_start = 1'b0;
   logic [287:0] wr_cw_lo = '0;
   logic [287:0] wr_cw_hi = '0;
   logic         wr_ready;
   logic         wr_beat_vld;
   logic [71:0]  wr_beat;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   ecc_burst_symbol_assembler dut (
      .clk (clk), .rst_n (rst_n),
      .rd_beat_vld (rd_beat_vld), .rd_beat (rd_beat), .rd_abort (rd_abort),
      .cw_vld (cw_vld), .cw_half (cw_half), .cw_data (cw_data),
      .wr_start (wr_start), .wr_cw_lo (wr_cw_lo), .wr_cw_hi (wr_cw_hi),
      .wr_ready (wr_ready), .wr_beat_vld (wr_beat_vld), .wr_beat (wr_beat)
   );

   // Expected code word: nibble k = lane k/4 of beat k%4
   function automatic logic [287:0] exp_cw(input logic [3:0][71:0] bt);
      logic [287:0] r;
      for (int k = 0; k < 72; k++) r[k*4 +: 4] = bt[k % 4][(k / 4) * 4 +: 4];
      return r;
   endfunction

   function automatic logic [71:0] exp_beat(input logic [287:0] cw, input int b);
      logic [71:0] r;
      for (int d = 0; d < 18; d++) r[d*4 +: 4] = cw[(4*d + b) * 4 +: 4];
      return r;
   endfunction

   function automatic logic [71:0] rnd72();
      return {8'($urandom), $urandom, $urandom};
   endfunction

   function automatic logic [287:0] rnd288();
      logic [287:0] r;
      for (int i = 0; i < 9; i++) r[i*32 +: 32] = $urandom;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [287:0] act, input logic [287:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Send four read beats of one half; returns the captured code word.
   task automatic rd_half(input logic [3:0][71:0] bt, input bit hidx, input int gap,
                          output logic [287:0] got);
      got = '0;
      for (int b = 0; b < 4; b++) begin
         rd_beat_vld = 1'b1;
         rd_beat     = bt[b];
         @(posedge clk); #1;
         rd_beat_vld = 1'b0;
         rd_beat     = rnd72();
         if (b == 3) begin
            chk(cw_vld === 1'b1, "R4 strobe after fourth beat", 288'(cw_vld), 288'(1));
            chk(cw_half === hidx, "R4 half index", 288'(cw_half), 288'(hidx));
            got = cw_data;
         end else begin
            chk(cw_vld === 1'b0, "R4 no strobe mid half", 288'(cw_vld), 288'(0));
         end
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            chk(cw_vld === 1'b0, "R4 idle beat no advance", 288'(cw_vld), 288'(0));
         end
      end
   endtask

   task automatic rd_line_check(input int gap, input string tag);
      logic [3:0][71:0] bt;
      logic [287:0]     got;
      for (int h = 0; h < 2; h++) begin
         for (int b = 0; b < 4; b++) bt[b] = rnd72();
         rd_half(bt, h[0], gap, got);
         chk(got === exp_cw(bt), tag, got, exp_cw(bt));
      end
   endtask

   // Run one write line; called one time unit after a clock edge.
   task automatic wr_line(input logic [287:0] c0, input logic [287:0] c1,
                          input bit poke, input bit chain,
                          input logic [287:0] n0, input logic [287:0] n1);
      logic [71:0] e;
      chk(wr_ready === 1'b1, "R8 ready before start", 288'(wr_ready), 288'(1));
      wr_start = 1'b1; wr_cw_lo = c0; wr_cw_hi = c1;
      @(posedge clk); #1;
      wr_start = 1'b0; wr_cw_lo = rnd288(); wr_cw_hi = rnd288();
      for (int b = 0; b < 8; b++) begin
         e = exp_beat(b < 4 ? c0 : c1, b % 4);
         chk(wr_beat_vld === 1'b1, "R7 beat valid", 288'(wr_beat_vld), 288'(1));
         chk(wr_beat === e, "R7 beat content", 288'(wr_beat), 288'(e));
         if (b < 7)
            chk(wr_ready === 1'b0, "R8 ready low while busy", 288'(wr_ready), 288'(0));
         else
            chk(wr_ready === 1'b1, "R9 ready on last beat", 288'(wr_ready), 288'(1));
         if (poke && b == 2) begin
            wr_start = 1'b1; wr_cw_lo = ~c0; wr_cw_hi = ~c1;
         end
         if (chain && b == 7) begin
            wr_start = 1'b1; wr_cw_lo = n0; wr_cw_hi = n1;
         end
         @(posedge clk); #1;
         wr_start = 1'b0;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [3:0][71:0] bt;
      logic [3:0][71:0] bad;
      logic [287:0]     clean;
      logic [287:0]     faulty;
      logic [287:0]     diff;
      logic [287:0]     mask;
      logic [287:0]     c0, c1, n0, n1;
      int               lane;
      logic [3:0]       stuck;
      void'($urandom(32'd20240611));

      // R1: reset state
      #1;
      chk(cw_vld === 1'b0, "R1 cw_vld in reset", 288'(cw_vld), 288'(0));
      chk(wr_beat_vld === 1'b0, "R1 wr_beat_vld in reset", 288'(wr_beat_vld), 288'(0));
      chk(wr_ready === 1'b1, "R1 wr_ready in reset", 288'(wr_ready), 288'(1));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      chk(cw_vld === 1'b0, "R1 cw_vld after reset", 288'(cw_vld), 288'(0));

      // R2: random lines, back-to-back and with gaps
      for (int i = 0; i < 20; i++) rd_line_check(0, "R2 mapping back-to-back");
      for (int i = 0; i < 20; i++) rd_line_check(i % 3 + 1, "R2 mapping with gaps");

      // R2: directed walking nibble, lane 5 beat 2 -> bits 16*5+8
      bt = '0; bt[2][5*4 +: 4] = 4'hA;
      rd_half(bt, 1'b0, 0, clean);
      mask = '0; mask[16*5 + 8 +: 4] = 4'hA;
      chk(clean === mask, "R2 lane 5 beat 2 position", clean, mask);
      bt = '0;
      rd_half(bt, 1'b1, 0, clean);

      // R3: data field from lanes 0..15, check field from lanes 16..17
      for (int b = 0; b < 4; b++) begin bt[b] = rnd72(); bt[b][71:64] = '0; end
      rd_half(bt, 1'b0, 0, clean);
      chk(clean[287:256] === 32'h0, "R3 check field isolated", 288'(clean[287:256]), 288'(0));
      for (int b = 0; b < 4; b++) begin bt[b] = '0; bt[b][71:64] = 8'($urandom); end
      rd_half(bt, 1'b1, 0, clean);
      chk(clean[255:0] === 256'h0, "R3 data field isolated", 288'(clean[255:0]), 288'(0));
      chk(clean === exp_cw(bt), "R3 check symbols", clean, exp_cw(bt));

      // R6: stuck lane only disturbs symbols 2d and 2d+1
      for (int t = 0; t < 12; t++) begin
         lane  = (t == 0) ? 0 : (t == 1) ? 17 : int'($urandom % 18);
         stuck = (t % 2 == 0) ? 4'h0 : 4'hF;
         for (int b = 0; b < 4; b++) begin
            bt[b]  = rnd72();
            bad[b] = bt[b];
            bad[b][lane*4 +: 4] = stuck;
         end
         rd_half(bt, 1'b0, 0, clean);
         rd_half(bad, 1'b1, 0, faulty);
         diff = clean ^ faulty;
         mask = '0; mask[lane*16 +: 16] = 16'hFFFF;
         chk((diff & ~mask) === '0, "R6 fault confined to two symbols", diff, diff & mask);
         chk(faulty[lane*16 +: 16] === {4{stuck}}, "R6 stuck symbols value",
             288'(faulty[lane*16 +: 16]), 288'({4{stuck}}));
      end

      // R5: abort after two beats, then a clean line
      for (int b = 0; b < 2; b++) begin
         rd_beat_vld = 1'b1; rd_beat = rnd72();
         @(posedge clk); #1;
      end
      rd_beat_vld = 1'b0; rd_abort = 1'b1;
      @(posedge clk); #1;
      rd_abort = 1'b0;
      chk(cw_vld === 1'b0, "R5 no strobe on abort", 288'(cw_vld), 288'(0));
      rd_line_check(0, "R5 clean line after abort");

      // R5: abort together with the fourth beat
      for (int b = 0; b < 3; b++) begin
         rd_beat_vld = 1'b1; rd_beat = rnd72();
         @(posedge clk); #1;
      end
      rd_beat = rnd72(); rd_abort = 1'b1;
      @(posedge clk); #1;
      rd_beat_vld = 1'b0; rd_abort = 1'b0;
      chk(cw_vld === 1'b0, "R5 abort wins over fourth beat", 288'(cw_vld), 288'(0));
      @(posedge clk); #1;
      chk(cw_vld === 1'b0, "R5 stays quiet after abort", 288'(cw_vld), 288'(0));
      rd_line_check(0, "R5 half order after coincident abort");

      // R7: random write lines
      for (int i = 0; i < 10; i++) begin
         c0 = rnd288(); c1 = rnd288();
         wr_line(c0, c1, 1'b0, 1'b0, '0, '0);
         chk(wr_beat_vld === 1'b0, "R7 idle after eight beats", 288'(wr_beat_vld), 288'(0));
         repeat (i % 3) @(posedge clk);
         #0;
      end

      // R8: start while busy is ignored
      c0 = rnd288(); c1 = rnd288();
      wr_line(c0, c1, 1'b1, 1'b0, '0, '0);
      chk(wr_beat_vld === 1'b0, "R8 ignored start launches nothing", 288'(wr_beat_vld), 288'(0));

      // R9: back-to-back lines with no gap
      c0 = rnd288(); c1 = rnd288(); n0 = rnd288(); n1 = rnd288();
      wr_line(c0, c1, 1'b0, 1'b1, n0, n1);
      for (int b = 0; b < 8; b++) begin
         chk(wr_beat_vld === 1'b1, "R9 chained beat valid", 288'(wr_beat_vld), 288'(1));
         chk(wr_beat === exp_beat(b < 4 ? n0 : n1, b % 4), "R9 chained beat content",
             288'(wr_beat), 288'(exp_beat(b < 4 ? n0 : n1, b % 4)));
         @(posedge clk); #1;
      end
      chk(wr_beat_vld === 1'b0, "R9 idle after chained line", 288'(wr_beat_vld), 288'(0));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule